// File: doc/BRIEF.md
# Masked-Compare Periodic Interrupt Timer

The block is an up-counter that runs on the system clock and raises an interrupt flag when its value matches a programmed compare value. A mask register removes chosen counter bits from the comparison, so one compare setting can match a whole group of counter values. When clear-on-match is set, the counter goes back to zero on the same edge that raises the flag. This gives a periodic interrupt every compare+1 cycles without software having to reload anything.

Software reaches the block through four word registers on a single-cycle write strobe. The registers are compare, mask, control/status and the counter itself. Read data is combinational from the word index. The control word holds the write-one-to-clear flag next to three enable bits. A debug-halt input can freeze the counter, but only when the control word allows it.

Top module: `mct_timer`

## Requirements
- R1: In a cycle where the counter runs and `((count ^ compare) & ~mask) == 0`, the flag (control bit 0) is 1 after the next edge. `irq` always equals the flag.
- R2: A control write with data bit 0 = 1 clears the flag. A control write with bit 0 = 0 leaves the flag unchanged.
- R3: With control bit 1 (clear-on-match) = 1, a match while running loads 0 into the counter on the same edge that sets the flag.
- R4: With control bit 1 = 0, a match does not disturb counting. The counter reads compare+1 on the edge that sets the flag.
- R5: With control bit 2 = 1 and `dbg_halt` = 1, the counter holds its value. With bit 2 = 0, `dbg_halt` has no effect.
- R6: Control bit 3 enables counting. When it is 1 (and no halt applies), the counter rises by one per clock. When it is 0, the counter holds.
- R7: After reset the registers read: control = 0x0000000C, compare = 0xFFFFFFFF, mask = 0, counter = 0. The counter starts running straight away.
- R8: Writes to control bits 31:4 are ignored, and those bits read as 0.
- R9: A mask bit of 1 excludes that counter bit from the match. For example, compare 0x13 with mask 0x3 first matches at count 0x10.
- R10: If a match and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R11: A counter write takes priority over both increment and clear-on-match in its cycle. The counter reads the written value after that edge.
- R12: The word index `bus_word` selects the register: 0 = compare, 1 = mask, 2 = control, 3 = counter (byte offsets 0x0, 0x4, 0x8, 0xC). Each register reads back what was written to it, apart from the R2 and R8 rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_halt | input | 1 | Debug halt request |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt level, equal to the flag |

## Verification
The hardest case to reach is a match landing in exactly the cycle of a software write. This covers a flag clear racing a hardware set, and a counter load racing clear-on-match. To reach it, the bench parks the counter with the enable off, loads a count a few steps below the compare value, and turns counting on. It then counts edges so that the control or counter write lands on the edge where the match is evaluated. The mask case is reached the same way: the counter starts at zero and runs up to the first value that differs from the compare only in masked bits.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [1:0] {
        SEL_CMP  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    // packed MSB first: bit3 run_en, bit2 halt_en, bit1 wrap_en, bit0 flag
    typedef struct packed {
        logic run_en;
        logic halt_en;
        logic wrap_en;
        logic flag;
    } ctrl_t;

    localparam int unsigned CTRL_W = 4;
    localparam ctrl_t CTRL_RST = '{run_en: 1'b1, halt_en: 1'b1, wrap_en: 1'b0, flag: 1'b0};

    function automatic logic timer_running(ctrl_t c, logic halt_req);
        return c.run_en & ~(c.halt_en & halt_req);
    endfunction

    function automatic logic flag_next(logic cur, logic set_req, logic clr_req);
        if (set_req)      return 1'b1;
        else if (clr_req) return 1'b0;
        else              return cur;
    endfunction

endpackage

// File: rtl/mct_match.sv
module mct_match #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] mask,
    output logic         eq
);
    logic [W-1:0] miss;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign miss[i] = (cnt[i] ^ cmp[i]) & ~mask[i];
    end

    assign eq = ~|miss;
endmodule

// File: rtl/mct_count.sv
module mct_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         wrap,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (wrap) cnt_q <= '0;
        else if (run)  cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/mct_regs.sv
module mct_regs
    import mct_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] mask_q,
    output ctrl_t        ctrl_q,
    output logic         cnt_load
);
    logic ctrl_we;
    logic flag_d;

    assign ctrl_we  = we && (sel == SEL_CTRL);
    assign cnt_load = we && (sel == SEL_CNT);
    assign flag_d   = flag_next(ctrl_q.flag, hit, ctrl_we && wdata[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '1;
            mask_q <= '0;
            ctrl_q <= CTRL_RST;
        end else begin
            if (we && sel == SEL_CMP)  cmp_q  <= wdata;
            if (we && sel == SEL_MASK) mask_q <= wdata;
            if (ctrl_we) begin
                ctrl_q.run_en  <= wdata[3];
                ctrl_q.halt_en <= wdata[2];
                ctrl_q.wrap_en <= wdata[1];
            end
            ctrl_q.flag <= flag_d;
        end
    end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbg_halt,
    input  logic         bus_we,
    input  logic [1:0]   bus_word,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq
);
    localparam int unsigned PAD_W = W - CTRL_W;

    reg_sel_e     sel;
    logic [W-1:0] cmp_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] cnt_q;
    ctrl_t        ctrl_q;
    logic         cnt_load;
    logic         eq;
    logic         run;
    logic         hit;

    assign sel = reg_sel_e'(bus_word);
    assign run = timer_running(ctrl_q, dbg_halt);
    assign hit = eq & run;

    mct_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
        .hit(hit), .cmp_q(cmp_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
        .cnt_load(cnt_load)
    );

    mct_match #(.W(W)) u_match (
        .cnt(cnt_q), .cmp(cmp_q), .mask(mask_q), .eq(eq)
    );

    mct_count #(.W(W)) u_count (
        .clk(clk), .rst(rst), .run(run), .wrap(hit & ctrl_q.wrap_en),
        .load(cnt_load), .load_val(bus_wdata), .cnt_q(cnt_q)
    );

    always_comb begin
        unique case (sel)
            SEL_CMP:  bus_rdata = cmp_q;
            SEL_MASK: bus_rdata = mask_q;
            SEL_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
            SEL_CNT:  bus_rdata = cnt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ctrl_q.flag;
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         dbg_halt,
    input logic         bus_we,
    input logic [1:0]   bus_word,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic         irq,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cmp_q,
    input logic [W-1:0] mask_q,
    input logic [3:0]   ctrl_bits
);
    logic running, matching, ctrl_wr, cnt_wr;

    assign running  = ctrl_bits[3] && !(ctrl_bits[2] && dbg_halt);
    assign matching = ((cnt_q ^ cmp_q) & ~mask_q) == '0;
    assign ctrl_wr  = bus_we && bus_word == 2'd2;
    assign cnt_wr   = bus_we && bus_word == 2'd3;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        running && matching |=> irq); // R1

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && bus_wdata[0] && !(running && matching) |=> !irq); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        irq && !(ctrl_wr && bus_wdata[0]) |=> irq); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        running && matching && ctrl_bits[1] && !cnt_wr |=> cnt_q == '0); // R3

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[2] && dbg_halt && !cnt_wr |=> $stable(cnt_q)); // R5

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(bus_wdata)); // R11

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        running && matching && ctrl_wr |=> irq); // R10

    always_comb begin
        if (!rst && bus_word == 2'd2)
            AST_RSVD_ZERO: assert (bus_rdata[W-1:4] == '0); // R8
    end
endmodule

bind mct_timer mct_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .dbg_halt(dbg_halt), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cnt_q(cnt_q), .cmp_q(cmp_q), .mask_q(mask_q),
    .ctrl_bits(ctrl_q)
);

// File: tb/sim_mct_timer.sv
`timescale 1ns/100ps
module sim_mct_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] A_CMP = 2'd0, A_MASK = 2'd1, A_CTRL = 2'd2, A_CNT = 2'd3;

    always #4 clk = ~clk;

    mct_timer u0 (
        .clk(clk), .rst(rst), .dbg_halt(dbg_halt), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_word = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        bus_word = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CNT, v);   check("R7 counter", v, 32'h0);
        check("R7 irq", {31'b0, irq}, 32'h0);
        step(10);
        rd(A_CNT, v);   check("R6 counts after reset", v, 32'd10);
        rd(A_CMP, v);   check("R7 compare", v, 32'hFFFF_FFFF);
        rd(A_MASK, v);  check("R7 mask", v, 32'h0);
        step(1);
        rd(A_CTRL, v);  check("R7 control", v, 32'h0000_000C);
    endtask

    task automatic t_match_nowrap;
        logic [31:0] v;
        wr(A_CTRL, 32'h0);
        wr(A_CMP, 32'd20);
        wr(A_MASK, 32'h0);
        wr(A_CNT, 32'd15);
        wr(A_CTRL, 32'h9);
        step(5);
        check("R1 no flag before match", {31'b0, irq}, 32'h0);
        rd(A_CNT, v); check("R6 count", v, 32'd20);
        step(1);
        check("R1 flag on match", {31'b0, irq}, 32'h1);
        rd(A_CNT, v); check("R4 counting continues", v, 32'd21);
        rd(A_CMP, v); check("R12 compare readback", v, 32'd20);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(A_CTRL, 32'h8);
        check("R2 write 0 keeps flag", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h9);
        check("R2 write 1 clears flag", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R12 control readback", v, 32'h8);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd0);
        wr(A_CMP, 32'd3);
        wr(A_CTRL, 32'hB);
        step(3);
        rd(A_CNT, v); check("R3 count at compare", v, 32'd3);
        check("R3 flag not yet", {31'b0, irq}, 32'h0);
        step(1);
        check("R3 flag set", {31'b0, irq}, 32'h1);
        rd(A_CNT, v); check("R3 cleared same edge", v, 32'd0);
        step(4);
        rd(A_CNT, v); check("R3 periodic wrap", v, 32'd0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd0);
        wr(A_CMP, 32'h13);
        wr(A_MASK, 32'h3);
        wr(A_CTRL, 32'h8);
        step(16);
        check("R9 no match below 0x10", {31'b0, irq}, 32'h0);
        rd(A_CNT, v); check("R9 count", v, 32'h10);
        rd(A_MASK, v); check("R12 mask readback", v, 32'h3);
        step(1);
        check("R9 masked match", {31'b0, irq}, 32'h1);
        rd(A_CNT, v); check("R9 count after", v, 32'h11);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_halt;
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_CMP, 32'h0);
        wr(A_CNT, 32'd50);
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'hC);
        step(5);
        rd(A_CNT, v); check("R5 halted", v, 32'd50);
        dbg_halt = 1'b0;
        step(5);
        rd(A_CNT, v); check("R5 resumes", v, 32'd55);
        wr(A_CTRL, 32'h8);
        dbg_halt = 1'b1;
        step(4);
        rd(A_CNT, v); check("R5 halt ignored when bit2=0", v, 32'd60);
        wr(A_CTRL, 32'h0);
        step(5);
        rd(A_CNT, v); check("R6 disabled holds", v, 32'd61);
        dbg_halt = 1'b0;
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd5);
        wr(A_CMP, 32'd8);
        wr(A_CTRL, 32'h9);
        step(3);
        wr(A_CTRL, 32'h9);
        check("R10 set wins over clear", {31'b0, irq}, 32'h1);
        rd(A_CNT, v); check("R10 count", v, 32'd9);
    endtask

    task automatic t_load_prio;
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd5);
        wr(A_CMP, 32'd8);
        wr(A_CTRL, 32'hB);
        step(3);
        wr(A_CNT, 32'h100);
        rd(A_CNT, v); check("R11 load beats wrap", v, 32'h100);
        check("R11 flag still set", {31'b0, irq}, 32'h1);
        step(1);
        rd(A_CNT, v); check("R11 counts from load", v, 32'h101);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); check("R8 reserved bits read 0", v, 32'h0000_000F);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_match_nowrap();
        t_w1c();
        t_wrap();
        t_mask();
        t_halt();
        t_collide();
        t_load_prio();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule